// File: doc/BRIEF.md
# Debug System-Speed Access Sequencer

This block manages a halted core's switch from its debug-generated clock to the system clock, so that one captured instruction runs at full speed. After the run it brings the core back to debug. A debug host starts a run by loading the restart code into the TAP instruction register. The run begins only when the TAP controller then reaches Run-Test/Idle. The block asks an external glitch-free clock multiplexer for the system clock and enables execution only once the multiplexer confirms the switch.

A memory access made at speed can be stalled for any number of cycles by the wait input. The block has no timeout. It holds the run until the completion strobe arrives with the wait input low. It then asks for the debug clock again and, once the multiplexer confirms, raises the debug acknowledge. A sticky completion bit in the status word tells a polling host that the instruction has finished. The flag that requested the run is recorded in the status word. An instruction class that may not run at speed is refused and reported through an error bit.

Top module: `sysspeed_seq`

## Requirements
- R1: A synchronous active-high reset leaves the clock request, the run enable and the debug acknowledge low, and the status word all zero. The block returns to the debug state on the debug clock.
- R2: The system-clock request `clk_sel_sys` rises only in the cycle after the TAP state reads Run-Test/Idle (code 4'hC). Before that, a restart load must have been accepted. Run-Test/Idle with no fresh restart load starts nothing.
- R3: `run_en` is high only while `clk_sel_sys` and `mux_ack` are both high. It rises one cycle after `mux_ack` is first seen high.
- R4: While `mem_wait` is high, `done_strobe` is ignored and `run_en` stays high for as long as the wait lasts, with no timeout.
- R5: A `done_strobe` with `mem_wait` low during the run drops `run_en` and `clk_sel_sys` on the next clock edge.
- R6: `dbg_ack` rises one cycle after `mux_ack` is seen low again. It is never high while the clock request or `mux_ack` is high.
- R7: Status bit 3 (completion) is set together with `dbg_ack`. It stays set until the next accepted restart load, which clears it on that load's edge.
- R8: Instruction class codes are 0 load, 1 store, 2 load-multiple, 3 store-multiple, and 4 to 7 other. A set system-speed flag on classes 4 to 7 sets status bit 4 (error) at the Run-Test/Idle edge. No clock request is made and the block goes back to debug. An accepted restart load clears bit 4.
- R9: Status bit 1 holds the system-speed flag of the latest launched run, so after a flagged run it reads 1 on return to debug.
- R10: Status bit 2 (busy) is high from the accepted restart load until the run completes or is refused. Status bits 0 and 7:5 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tap_ir | input | 4 | Current decoded TAP instruction code (restart = 4'b0100) |
| tap_state | input | 4 | Current TAP controller state code (Run-Test/Idle = 4'hC) |
| sys_flag | input | 1 | System-speed flag of the captured instruction |
| instr_class | input | 3 | Class of the captured instruction |
| mem_wait | input | 1 | Memory wait; high stalls the running access |
| done_strobe | input | 1 | Instruction completion strobe from the pipeline |
| mux_ack | input | 1 | Clock multiplexer reports system clock selected |
| clk_sel_sys | output | 1 | Request to the multiplexer for the system clock |
| run_en | output | 1 | Execution enable at system speed |
| dbg_ack | output | 1 | Debug acknowledge after a completed run |
| status | output | 8 | Debug status word |

## Verification
The hardest situation to reach from the ports is a completion strobe that arrives during a memory stall. This must happen after the multiplexer handshake has settled, and later the wait must release while the strobe is still present. The bench models the multiplexer as a two-stage delay on the clock request, so every handoff goes through a real request and acknowledge lag. Every run holds the strobe high through a stall of swept length from zero to four cycles before the wait drops. This is repeated for every class code and both flag values, so refused, flagged and unflagged runs all follow one another through the DONE state.

// File: rtl/sysspd_pkg.sv
package sysspd_pkg;

  localparam int unsigned CLASS_W  = 3;
  localparam int unsigned STATUS_W = 8;

  localparam int unsigned BIT_FLAG = 1;
  localparam int unsigned BIT_BUSY = 2;
  localparam int unsigned BIT_CMPL = 3;
  localparam int unsigned BIT_ERR  = 4;

  typedef enum logic [2:0] {
    ST_DEBUG         = 3'd0,
    ST_WAIT_IDLE     = 3'd1,
    ST_SWITCH_TO_SYS = 3'd2,
    ST_RUN           = 3'd3,
    ST_SWITCH_TO_DBG = 3'd4,
    ST_DONE          = 3'd5
  } seq_state_e;

  // Memory transfer classes (single and multiple loads/stores) occupy codes 0..3.
  function automatic logic class_allows_sysspeed(input logic [CLASS_W-1:0] cls);
    return cls <= CLASS_W'(3);
  endfunction

  function automatic logic [STATUS_W-1:0] pack_status(input logic flag,
                                                      input logic busy,
                                                      input logic cmpl,
                                                      input logic err);
    logic [STATUS_W-1:0] w;
    w           = '0;
    w[BIT_FLAG] = flag;
    w[BIT_BUSY] = busy;
    w[BIT_CMPL] = cmpl;
    w[BIT_ERR]  = err;
    return w;
  endfunction

endpackage

// File: rtl/sysspd_restart_edge.sv
module sysspd_restart_edge #(
  parameter int unsigned      IR_W         = 4,
  parameter logic [IR_W-1:0]  RESTART_CODE = 4'b0100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IR_W-1:0] tap_ir,
  output logic            restart_load
);

  logic is_restart;
  logic is_restart_q;

  assign is_restart = (tap_ir == RESTART_CODE);

  always_ff @(posedge clk) begin
    if (rst) is_restart_q <= 1'b0;
    else     is_restart_q <= is_restart;
  end

  // A load is the first cycle the restart code appears in the register.
  assign restart_load = is_restart && !is_restart_q;

endmodule

// File: rtl/sysspd_fsm.sv
module sysspd_fsm
  import sysspd_pkg::*;
#(
  parameter int unsigned       TAP_W     = 4,
  parameter logic [TAP_W-1:0]  IDLE_CODE = 4'hC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_load,
  input  logic [TAP_W-1:0] tap_state,
  input  logic             sys_flag,
  input  logic             class_ok,
  input  logic             mux_ack,
  input  logic             done_strobe,
  input  logic             mem_wait,
  output seq_state_e       state,
  output logic             restart_take,
  output logic             launch,
  output logic             refuse,
  output logic             finish
);

  seq_state_e state_nx;
  logic       at_idle;
  logic       parked;
  logic       run_over;
  logic       on_sys;

  assign at_idle      = (tap_state == IDLE_CODE);
  assign parked       = (state == ST_DEBUG) || (state == ST_DONE);
  assign restart_take = restart_load && parked;
  assign launch       = (state == ST_WAIT_IDLE) && at_idle && (!sys_flag || class_ok);
  assign refuse       = (state == ST_WAIT_IDLE) && at_idle && sys_flag && !class_ok;
  assign run_over     = (state == ST_RUN) && done_strobe && !mem_wait;
  assign on_sys       = (state == ST_SWITCH_TO_SYS) && mux_ack;
  assign finish       = (state == ST_SWITCH_TO_DBG) && !mux_ack;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_DEBUG, ST_DONE: if (restart_take) state_nx = ST_WAIT_IDLE;
      ST_WAIT_IDLE: begin
        if (launch)      state_nx = ST_SWITCH_TO_SYS;
        else if (refuse) state_nx = ST_DEBUG;
      end
      ST_SWITCH_TO_SYS: if (on_sys)   state_nx = ST_RUN;
      ST_RUN:           if (run_over) state_nx = ST_SWITCH_TO_DBG;
      ST_SWITCH_TO_DBG: if (finish)   state_nx = ST_DONE;
      default:                        state_nx = ST_DEBUG;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_DEBUG;
    else     state <= state_nx;
  end

endmodule

// File: rtl/sysspd_status.sv
module sysspd_status
  import sysspd_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                restart_take,
  input  logic                launch,
  input  logic                refuse,
  input  logic                finish,
  input  logic                sys_flag,
  input  logic                busy,
  output logic [STATUS_W-1:0] status
);

  logic flag_q;
  logic cmpl_q;
  logic err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      cmpl_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (restart_take) begin
        flag_q <= 1'b0;
        cmpl_q <= 1'b0;
        err_q  <= 1'b0;
      end
      if (launch) flag_q <= sys_flag;
      if (finish) cmpl_q <= 1'b1;
      if (refuse) err_q  <= 1'b1;
    end
  end

  assign status = pack_status(flag_q, busy, cmpl_q, err_q);

endmodule

// File: rtl/sysspeed_seq.sv
module sysspeed_seq
  import sysspd_pkg::*;
#(
  parameter int unsigned       IR_W         = 4,
  parameter logic [IR_W-1:0]   RESTART_CODE = 4'b0100,
  parameter int unsigned       TAP_W        = 4,
  parameter logic [TAP_W-1:0]  IDLE_CODE    = 4'hC
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [IR_W-1:0]     tap_ir,
  input  logic [TAP_W-1:0]    tap_state,
  input  logic                sys_flag,
  input  logic [CLASS_W-1:0]  instr_class,
  input  logic                mem_wait,
  input  logic                done_strobe,
  input  logic                mux_ack,
  output logic                clk_sel_sys,
  output logic                run_en,
  output logic                dbg_ack,
  output logic [STATUS_W-1:0] status
);

  // Named internal events, visible to the bound checker.
  logic       restart_load;
  logic       restart_take;
  logic       launch;
  logic       refuse;
  logic       finish;
  logic       busy;
  seq_state_e state;

  sysspd_restart_edge #(
    .IR_W         (IR_W),
    .RESTART_CODE (RESTART_CODE)
  ) u_edge (
    .clk          (clk),
    .rst          (rst),
    .tap_ir       (tap_ir),
    .restart_load (restart_load)
  );

  sysspd_fsm #(
    .TAP_W     (TAP_W),
    .IDLE_CODE (IDLE_CODE)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .restart_load (restart_load),
    .tap_state    (tap_state),
    .sys_flag     (sys_flag),
    .class_ok     (class_allows_sysspeed(instr_class)),
    .mux_ack      (mux_ack),
    .done_strobe  (done_strobe),
    .mem_wait     (mem_wait),
    .state        (state),
    .restart_take (restart_take),
    .launch       (launch),
    .refuse       (refuse),
    .finish       (finish)
  );

  assign busy = (state == ST_WAIT_IDLE) || (state == ST_SWITCH_TO_SYS) ||
                (state == ST_RUN)       || (state == ST_SWITCH_TO_DBG);

  sysspd_status u_status (
    .clk          (clk),
    .rst          (rst),
    .restart_take (restart_take),
    .launch       (launch),
    .refuse       (refuse),
    .finish       (finish),
    .sys_flag     (sys_flag),
    .busy         (busy),
    .status       (status)
  );

  assign clk_sel_sys = (state == ST_SWITCH_TO_SYS) || (state == ST_RUN);
  assign run_en      = (state == ST_RUN);
  assign dbg_ack     = (state == ST_DONE);

endmodule

// File: rtl/sysspeed_seq_chk.sv
module sysspeed_seq_chk
  import sysspd_pkg::*;
#(
  parameter int unsigned       TAP_W     = 4,
  parameter logic [TAP_W-1:0]  IDLE_CODE = 4'hC
) (
  input logic                clk,
  input logic                rst,
  input logic [TAP_W-1:0]    tap_state,
  input logic                mem_wait,
  input logic                mux_ack,
  input logic                clk_sel_sys,
  input logic                run_en,
  input logic                dbg_ack,
  input logic [STATUS_W-1:0] status,
  input logic                restart_take
);

  AST_SEL_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_sel_sys) |-> $past(tap_state) == IDLE_CODE); // R2

  AST_RUN_ON_SYS_CLK: assert property (@(posedge clk) disable iff (rst)
    run_en |-> (clk_sel_sys && mux_ack)); // R3

  AST_WAIT_HOLDS_RUN: assert property (@(posedge clk) disable iff (rst)
    (run_en && mem_wait) |=> run_en); // R4

  AST_ACK_ON_DBG_CLK: assert property (@(posedge clk) disable iff (rst)
    dbg_ack |-> (!clk_sel_sys && !mux_ack)); // R6

  AST_CMPL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (status[BIT_CMPL] && !restart_take) |=> status[BIT_CMPL]); // R7

  AST_REFUSE_NO_SWITCH: assert property (@(posedge clk) disable iff (rst)
    $rose(status[BIT_ERR]) |-> !clk_sel_sys); // R8

  AST_SPARE_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (status[0] == 1'b0) && (status[STATUS_W-1:5] == '0)); // R10

endmodule

bind sysspeed_seq sysspeed_seq_chk #(
  .TAP_W     (TAP_W),
  .IDLE_CODE (IDLE_CODE)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .tap_state    (tap_state),
  .mem_wait     (mem_wait),
  .mux_ack      (mux_ack),
  .clk_sel_sys  (clk_sel_sys),
  .run_en       (run_en),
  .dbg_ack      (dbg_ack),
  .status       (status),
  .restart_take (restart_take)
);

// File: tb/test_sysspeed_seq.sv
module test_sysspeed_seq;

  localparam logic [3:0] RESTART = 4'b0100;
  localparam logic [3:0] OTHER   = 4'b0001;
  localparam logic [3:0] IDLE    = 4'hC;
  localparam logic [3:0] NOTIDLE = 4'h1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] tap_ir = OTHER;
  logic [3:0] tap_state = NOTIDLE;
  logic       sys_flag = 1'b0;
  logic [2:0] instr_class = 3'd0;
  logic       mem_wait = 1'b0;
  logic       done_strobe = 1'b0;
  logic       mux_ack = 1'b0;
  logic       mux_d = 1'b0;
  logic       clk_sel_sys;
  logic       run_en;
  logic       dbg_ack;
  logic [7:0] status;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  sysspeed_seq i_sysspeed_seq (
    .clk         (clk),
    .rst         (rst),
    .tap_ir      (tap_ir),
    .tap_state   (tap_state),
    .sys_flag    (sys_flag),
    .instr_class (instr_class),
    .mem_wait    (mem_wait),
    .done_strobe (done_strobe),
    .mux_ack     (mux_ack),
    .clk_sel_sys (clk_sel_sys),
    .run_en      (run_en),
    .dbg_ack     (dbg_ack),
    .status      (status)
  );

  always #2 clk = ~clk;

  // One step: go to the falling edge, advance the two-stage multiplexer model.
  task automatic step();
    @(negedge clk);
    mux_ack = mux_d;
    mux_d   = clk_sel_sys;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic one_run(input int cls, input bit flag, input int nwait);
    bit legal;
    legal = !flag || (cls <= 3);
    tap_ir = OTHER; tap_state = NOTIDLE;
    step();
    tap_ir = RESTART; sys_flag = flag; instr_class = 3'(cls);
    step();
    tap_ir = OTHER;
    chk(status[3] == 1'b0, "R7 cmpl cleared by load", int'(status[3]), 0);
    chk(status[2] == 1'b1, "R10 busy after load", int'(status[2]), 1);
    step(); step();
    chk(clk_sel_sys == 1'b0, "R2 no request before idle", int'(clk_sel_sys), 0);
    tap_state = IDLE;
    step();
    tap_state = NOTIDLE;
    if (!legal) begin
      chk(status[4] == 1'b1, "R8 error bit", int'(status[4]), 1);
      chk(clk_sel_sys == 1'b0, "R8 no clock request", int'(clk_sel_sys), 0);
      chk(status[2] == 1'b0, "R10 busy drops on refuse", int'(status[2]), 0);
      return;
    end
    chk(status[4] == 1'b0, "R8 no error on legal", int'(status[4]), 0);
    chk(clk_sel_sys == 1'b1, "R2 request after idle", int'(clk_sel_sys), 1);
    chk(run_en == 1'b0, "R3 no run before ack", int'(run_en), 0);
    step();
    chk(run_en == 1'b0, "R3 still waiting ack", int'(run_en), 0);
    step();
    chk(run_en == 1'b1, "R3 run after ack", int'(run_en), 1);
    mem_wait = 1'b1; done_strobe = 1'b1;
    for (int w = 0; w < nwait; w++) begin
      step();
      chk(run_en == 1'b1, "R4 held by wait", int'(run_en), 1);
    end
    mem_wait = 1'b0;
    step();
    done_strobe = 1'b0;
    chk(run_en == 1'b0, "R5 run ends", int'(run_en), 0);
    chk(clk_sel_sys == 1'b0, "R5 request drops", int'(clk_sel_sys), 0);
    step();
    chk(dbg_ack == 1'b0, "R6 ack waits mux", int'(dbg_ack), 0);
    chk(status[3] == 1'b0, "R7 cmpl with ack", int'(status[3]), 0);
    step();
    chk(dbg_ack == 1'b1, "R6 ack after mux", int'(dbg_ack), 1);
    chk(status[3] == 1'b1, "R7 cmpl set", int'(status[3]), 1);
    chk(status[1] == flag, "R9 recorded flag", int'(status[1]), int'(flag));
    chk(status[2] == 1'b0, "R10 busy clear", int'(status[2]), 0);
    tap_state = IDLE;
    step(); step(); step();
    tap_state = NOTIDLE;
    chk(clk_sel_sys == 1'b0, "R2 idle without load", int'(clk_sel_sys), 0);
    chk(status[3] == 1'b1, "R7 cmpl sticky", int'(status[3]), 1);
    chk(dbg_ack == 1'b1, "R6 ack held", int'(dbg_ack), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    step(); step(); step();
    rst = 1'b0;
    chk(status == 8'h00, "R1 status reset", int'(status), 0);
    chk(dbg_ack == 1'b0, "R1 ack reset", int'(dbg_ack), 0);
    chk(clk_sel_sys == 1'b0, "R1 request reset", int'(clk_sel_sys), 0);
    chk(run_en == 1'b0, "R1 run reset", int'(run_en), 0);
    for (int nw = 0; nw <= 4; nw++)
      for (int c = 0; c < 8; c++)
        for (int f = 0; f < 2; f++) begin
          one_run(c, f[0], nw);
          chk(status[0] == 1'b0 && status[7:5] == 3'd0, "R10 spare bits", int'(status), 0);
        end
    finish_run();
  end

endmodule